// File: doc/BRIEF.md
# TDM Time Slot Interchange Switch

This block moves 64 kbit/s byte channels between a group of synchronous TDM lines. Every line carries one byte per time slot. A frame holds a fixed number of slots and lasts 125 us. All lines share one slot timing: a slot tick presents one byte from every input port at once, together with the slot number. A frame-start flag marks the tick that carries slot 0. Each received byte is stored in a byte-wide RAM at an address built from its port and slot.

For every output (port, slot), a programmable connection table names a source (port, slot) and a valid flag. The block reads the mapped byte and sends it in that output channel, so any channel can reach any other channel in both time and space. The RAM holds two copies of every channel and the two banks swap at each frame start. One frame is stored while the frame before it is read out, so each channel arrives exactly one frame late. Table writes go to a shadow copy that becomes active at the next frame start.

Internally, each slot is handled as a short burst that takes one RAM write and one RAM read per port. The complete output slot then leaves as a single registered word.

Top module: `tsi_switch`

## Requirements
- R1: When the active table entry for output (p, s) is valid with source (sp, ss), output port p in slot s of frame f carries the byte received on port sp in slot ss of frame f-1. Output byte p sits at bits [8p+7:8p] of `tx_data`, and input byte p sits at the same position of `rx_data`.
- R2: When the active entry for an output channel is invalid (valid bit 0), that output byte is 0xFF.
- R3: Until one complete frame has been stored, every output byte is 0xFF. That covers every slot of the first frame after reset, which counts from the first tick that has `frame_sync` high.
- R4: A table write takes effect at the next slot tick that has `frame_sync` high. Every slot of a frame uses the table as it stood at that frame's start.
- R5: One source channel may feed any number of output channels in the same frame.
- R6: Each slot tick produces exactly one `tx_valid` pulse, one cycle long. It appears on the (NUM_PORTS+2)th rising edge after the edge that samples `slot_tick`, and `tx_slot` equals that tick's `slot_num`. Slot ticks must be at least NUM_PORTS+3 cycles apart, and `slot_num` must be below NUM_SLOTS.
- R7: An output channel mapped to its own (port, slot) returns the previous frame's byte, never the byte being stored in the current frame.
- R8: `rx_data` and `slot_num` are sampled only on a slot tick. Their values in other cycles have no effect.
- R9: After reset, `tx_valid` is 0 and `tx_data` is all 0xFF bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_tick | input | 1 | One-cycle strobe: a new slot of input bytes is present |
| frame_sync | input | 1 | With slot_tick, marks slot 0 of a new frame |
| slot_num | input | SLOT_W | Slot number of the current tick |
| rx_data | input | NUM_PORTS*8 | One input byte per port, port p at [8p+7:8p] |
| map_we | input | 1 | Connection-table write strobe |
| map_dst_port | input | PORT_W | Output port of the entry being written |
| map_dst_slot | input | SLOT_W | Output slot of the entry being written |
| map_src_port | input | PORT_W | Source port for that output |
| map_src_slot | input | SLOT_W | Source slot for that output |
| map_valid | input | 1 | 1 = route the source, 0 = send the idle byte |
| tx_valid | output | 1 | One-cycle pulse: a full output slot is on tx_data |
| tx_slot | output | SLOT_W | Slot number of the output word |
| tx_data | output | NUM_PORTS*8 | One output byte per port, port p at [8p+7:8p] |

## Verification
The bench drives a byte value that is unique within each frame and changes from frame to frame. A byte taken from the wrong frame, bank, port or slot therefore shows up as a mismatch.

The first table is a full permutation that shifts both port and slot, with scattered invalid entries. It separates true space and time switching from identity routing, and it exercises idle insertion. A rewrite in the middle of a frame checks three things:
- broadcast of one source to a whole output port;
- self-mapped channels, which must show the previous frame;
- an entry switched off.

The frames on either side of that rewrite show whether the change waited for the frame boundary. Random values between ticks show whether anything outside a tick leaks into the stored data.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/tsi_slot_ram.sv
// Simple dual-port byte RAM with a registered read, one write per cycle.
module tsi_slot_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 480,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/tsi_frame_ctrl.sv
// Bank ownership and "one full frame stored" tracking.
module tsi_frame_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  output logic wr_bank,
  output logic primed
);
  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_bank <= 1'b0;
      seen_q  <= 1'b0;
      primed  <= 1'b0;
    end else if (frame_start) begin
      wr_bank <= ~wr_bank;
      seen_q  <= 1'b1;
      primed  <= primed | seen_q;
    end
  end

  AST_PRIMED_ORDER: assert property (@(posedge clk) disable iff (rst)
    $rose(primed) |-> $past(seen_q)); // R3

  AST_PRIMED_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(primed) |-> $past(frame_start)); // R3
endmodule

// File: rtl/tsi_conn_map.sv
// Connection table: shadow copy written at any time, active copy loaded at frame start.
module tsi_conn_map #(
  parameter int CHANS   = 240,
  parameter int ENTRY_W = 10,
  parameter int IDX_W   = $clog2(CHANS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_entry,
  input  logic               commit,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rd_entry
);
  logic [ENTRY_W-1:0] act_arr [CHANS];

  for (genvar e = 0; e < CHANS; e++) begin : g_ent
    logic [ENTRY_W-1:0] shadow_q;
    logic [ENTRY_W-1:0] live_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        shadow_q <= '0;
        live_q   <= '0;
      end else begin
        if (wr_en && (wr_idx == IDX_W'(e))) shadow_q <= wr_entry;
        if (commit) live_q <= shadow_q;
      end
    end

    assign act_arr[e] = live_q;
  end

  assign rd_entry = act_arr[rd_idx];
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int NUM_PORTS = 10,
  parameter int NUM_SLOTS = 24,
  localparam int PORT_W  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int SLOT_W  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int CHANS   = NUM_PORTS * NUM_SLOTS,
  localparam int IDX_W   = $clog2(CHANS),
  localparam int ADDR_W  = $clog2(2 * CHANS),
  localparam int ENTRY_W = 1 + PORT_W + SLOT_W,
  localparam int BUS_W   = NUM_PORTS * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slot_tick,
  input  logic              frame_sync,
  input  logic [SLOT_W-1:0] slot_num,
  input  logic [BUS_W-1:0]  rx_data,
  input  logic              map_we,
  input  logic [PORT_W-1:0] map_dst_port,
  input  logic [SLOT_W-1:0] map_dst_slot,
  input  logic [PORT_W-1:0] map_src_port,
  input  logic [SLOT_W-1:0] map_src_slot,
  input  logic              map_valid,
  output logic              tx_valid,
  output logic [SLOT_W-1:0] tx_slot,
  output logic [BUS_W-1:0]  tx_data
);
  localparam logic [PORT_W-1:0] LAST_PORT = PORT_W'(NUM_PORTS - 1);

  logic frame_start;
  logic wr_bank;
  logic primed;
  assign frame_start = slot_tick & frame_sync;

  tsi_frame_ctrl i_frame_ctrl (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .wr_bank     (wr_bank),
    .primed      (primed)
  );

  // Table write port
  logic               map_ok;
  logic [IDX_W-1:0]   map_wr_idx;
  logic [ENTRY_W-1:0] map_wr_entry;
  assign map_ok       = map_we && (int'(map_dst_port) < NUM_PORTS) &&
                        (int'(map_dst_slot) < NUM_SLOTS);
  assign map_wr_idx   = IDX_W'(map_dst_port) * IDX_W'(NUM_SLOTS) + IDX_W'(map_dst_slot);
  assign map_wr_entry = {map_valid, map_src_port, map_src_slot};

  // Slot burst sequencer: one port per cycle
  logic [BUS_W-1:0]  hold_q;
  logic [SLOT_W-1:0] cur_slot_q;
  logic              seq_busy_q;
  logic [PORT_W-1:0] seq_cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= '0;
      cur_slot_q <= '0;
      seq_busy_q <= 1'b0;
      seq_cnt_q  <= '0;
    end else if (slot_tick) begin
      hold_q     <= rx_data;
      cur_slot_q <= slot_num;
      seq_busy_q <= 1'b1;
      seq_cnt_q  <= '0;
    end else if (seq_busy_q) begin
      if (seq_cnt_q == LAST_PORT) begin
        seq_busy_q <= 1'b0;
      end else begin
        seq_cnt_q <= seq_cnt_q + 1'b1;
      end
    end
  end

  // Table lookup for the output channel being served
  logic [IDX_W-1:0]   look_idx;
  logic [ENTRY_W-1:0] look_entry;
  logic               look_valid;
  logic [PORT_W-1:0]  look_port;
  logic [SLOT_W-1:0]  look_slot;
  assign look_idx   = IDX_W'(seq_cnt_q) * IDX_W'(NUM_SLOTS) + IDX_W'(cur_slot_q);
  assign look_valid = look_entry[ENTRY_W-1];
  assign look_port  = look_entry[ENTRY_W-2 -: PORT_W];
  assign look_slot  = look_entry[SLOT_W-1:0];

  tsi_conn_map #(
    .CHANS   (CHANS),
    .ENTRY_W (ENTRY_W),
    .IDX_W   (IDX_W)
  ) i_conn_map (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (map_ok),
    .wr_idx   (map_wr_idx),
    .wr_entry (map_wr_entry),
    .commit   (frame_start),
    .rd_idx   (look_idx),
    .rd_entry (look_entry)
  );

  // Store to the current bank, fetch from the other one
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic [BYTE_W-1:0] wr_byte;
  logic [BYTE_W-1:0] ram_rdata;
  assign wr_addr = (wr_bank ? ADDR_W'(CHANS) : '0) +
                   ADDR_W'(seq_cnt_q) * ADDR_W'(NUM_SLOTS) + ADDR_W'(cur_slot_q);
  assign rd_addr = (wr_bank ? '0 : ADDR_W'(CHANS)) +
                   ADDR_W'(look_port) * ADDR_W'(NUM_SLOTS) + ADDR_W'(look_slot);
  assign wr_byte = hold_q[seq_cnt_q * BYTE_W +: BYTE_W];

  tsi_slot_ram #(
    .DATA_W (BYTE_W),
    .DEPTH  (2 * CHANS),
    .ADDR_W (ADDR_W)
  ) i_slot_ram (
    .clk     (clk),
    .wr_en   (seq_busy_q),
    .wr_addr (wr_addr),
    .wr_data (wr_byte),
    .rd_addr (rd_addr),
    .rd_data (ram_rdata)
  );

  // Read pipeline and output assembly
  logic              rd_vld_q;
  logic              rd_use_q;
  logic              rd_last_q;
  logic [PORT_W-1:0] rd_port_q;
  logic [BUS_W-1:0]  out_acc_q;
  logic              fin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld_q  <= 1'b0;
      rd_use_q  <= 1'b0;
      rd_last_q <= 1'b0;
      rd_port_q <= '0;
      out_acc_q <= {NUM_PORTS{IDLE_BYTE}};
      fin_q     <= 1'b0;
      tx_valid  <= 1'b0;
      tx_slot   <= '0;
      tx_data   <= {NUM_PORTS{IDLE_BYTE}};
    end else begin
      rd_vld_q  <= seq_busy_q;
      rd_use_q  <= look_valid & primed;
      rd_last_q <= seq_busy_q && (seq_cnt_q == LAST_PORT);
      rd_port_q <= seq_cnt_q;
      if (rd_vld_q) begin
        out_acc_q[rd_port_q * BYTE_W +: BYTE_W] <= rd_use_q ? ram_rdata : IDLE_BYTE;
      end
      fin_q    <= rd_vld_q & rd_last_q;
      tx_valid <= fin_q;
      if (fin_q) begin
        tx_data <= out_acc_q;
        tx_slot <= cur_slot_q;
      end
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    slot_tick |-> !(seq_busy_q || rd_vld_q || fin_q)); // R6

  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst)
    slot_tick |-> (int'(slot_num) < NUM_SLOTS)); // R6

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    tx_valid |=> !tx_valid); // R6

  AST_BANK_SPLIT: assert property (@(posedge clk) disable iff (rst)
    (seq_busy_q && look_valid) |->
      ((int'(wr_addr) >= CHANS) != (int'(rd_addr) >= CHANS))); // R7

  AST_IDLE_UNPRIMED: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !primed) |-> (tx_data == {NUM_PORTS{IDLE_BYTE}})); // R3
endmodule

// File: tb/test_tsi_switch.sv
module test_tsi_switch;
  localparam int NP = 10;
  localparam int NS = 24;
  localparam int PW = 4;
  localparam int SW = 5;
  localparam int LAT = NP + 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst;
  logic           slot_tick;
  logic           frame_sync;
  logic [SW-1:0]  slot_num;
  logic [NP*8-1:0] rx_data;
  logic           map_we;
  logic [PW-1:0]  map_dst_port;
  logic [SW-1:0]  map_dst_slot;
  logic [PW-1:0]  map_src_port;
  logic [SW-1:0]  map_src_slot;
  logic           map_valid;
  logic           tx_valid;
  logic [SW-1:0]  tx_slot;
  logic [NP*8-1:0] tx_data;

  tsi_switch #(.NUM_PORTS(NP), .NUM_SLOTS(NS)) i_tsi_switch (
    .clk(clk), .rst(rst), .slot_tick(slot_tick), .frame_sync(frame_sync),
    .slot_num(slot_num), .rx_data(rx_data), .map_we(map_we),
    .map_dst_port(map_dst_port), .map_dst_slot(map_dst_slot),
    .map_src_port(map_src_port), .map_src_slot(map_src_slot),
    .map_valid(map_valid), .tx_valid(tx_valid), .tx_slot(tx_slot),
    .tx_data(tx_data)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int              due;
    int              slot;
    logic [NP*8-1:0] data;
    logic [NP*4-1:0] tags;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model state: {valid, src_port[3:0], src_slot[4:0]}
  logic [7:0] cur_b  [NP][NS];
  logic [7:0] prev_b [NP][NS];
  logic [9:0] pend_m [NP][NS];
  logic [9:0] act_m  [NP][NS];

  function automatic string tag_name(int c);
    case (c)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      7: return "R7";
      8: return "R8";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [7:0] chan_val(int p, int s, int f);
    return 8'((p * NS + s + f * 16) % 240);
  endfunction

  task automatic set_map(int dp, int ds, bit v, int sp, int ss);
    map_dst_port = PW'(dp);
    map_dst_slot = SW'(ds);
    map_src_port = PW'(sp);
    map_src_slot = SW'(ss);
    map_valid    = v;
    map_we       = 1'b1;
    pend_m[dp][ds] = {v, 4'(sp), 5'(ss)};
    @(negedge clk);
    map_we = 1'b0;
  endtask

  task automatic run_slot(int f, int s);
    exp_t it;
    if (s == 0) begin
      for (int p = 0; p < NP; p++)
        for (int k = 0; k < NS; k++) begin
          prev_b[p][k] = cur_b[p][k];
          act_m[p][k]  = pend_m[p][k];
        end
    end
    for (int p = 0; p < NP; p++) begin
      cur_b[p][s] = chan_val(p, s, f);
      rx_data[p*8 +: 8] = cur_b[p][s];
    end
    slot_num   = SW'(s);
    frame_sync = (s == 0);
    slot_tick  = 1'b1;
    it.due  = cyc + LAT;
    it.slot = s;
    for (int p = 0; p < NP; p++) begin
      logic [9:0] e;
      int tg;
      e = act_m[p][s];
      if (f == 0) begin
        it.data[p*8 +: 8] = 8'hFF; tg = 3;
      end else if (!e[9]) begin
        it.data[p*8 +: 8] = 8'hFF; tg = 2;
      end else begin
        it.data[p*8 +: 8] = prev_b[int'(e[8:5])][int'(e[4:0])];
        if (p == 0 && f >= 3) tg = 5;
        else if (p == 1 && f >= 3) tg = 7;
        else if (f == 3 || (f == 2 && s > 10)) tg = 4;
        else if (f == 1) tg = 8;
        else tg = 1;
      end
      it.tags[p*4 +: 4] = 4'(tg);
    end
    q.push_back(it);
    @(negedge clk);
    slot_tick  = 1'b0;
    frame_sync = 1'b0;
    // R8: noise between ticks must not reach the stored data
    rx_data  = (NP*8)'({$urandom(), $urandom(), $urandom()});
    slot_num = SW'($urandom());
    repeat (15) @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && tx_valid) begin
      if (q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R6: unexpected output pulse at cycle %0d (actual slot %0d, expected none)",
                 cyc, tx_slot);
      end else begin
        exp_t it;
        it = q.pop_front();
        checks++;
        if (cyc != it.due || int'(tx_slot) != it.slot) begin
          fails++;
          $display("FAIL R6: timing/slot actual cyc %0d slot %0d, expected cyc %0d slot %0d",
                   cyc, tx_slot, it.due, it.slot);
        end
        for (int p = 0; p < NP; p++) begin
          checks++;
          if (tx_data[p*8 +: 8] !== it.data[p*8 +: 8]) begin
            fails++;
            $display("FAIL %s: slot %0d port %0d actual %h expected %h",
                     tag_name(int'(it.tags[p*4 +: 4])), it.slot, p,
                     tx_data[p*8 +: 8], it.data[p*8 +: 8]);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R6: watchdog expired (actual running, expected finished)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; slot_tick = 1'b0; frame_sync = 1'b0; slot_num = '0; rx_data = '0;
    map_we = 1'b0; map_dst_port = '0; map_dst_slot = '0; map_src_port = '0;
    map_src_slot = '0; map_valid = 1'b0;
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < NS; s++) begin
        cur_b[p][s] = 8'hFF; prev_b[p][s] = 8'hFF;
        pend_m[p][s] = '0; act_m[p][s] = '0;
      end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    checks++;
    if (tx_valid !== 1'b0 || tx_data !== {NP{8'hFF}}) begin
      fails++;
      $display("FAIL R9: reset actual valid %b data %h, expected 0 / all FF", tx_valid, tx_data);
    end
    // R1: permutation across both ports and slots, some entries invalid (R2)
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < NS; s++)
        set_map(p, s, ((p + s) % 7) != 0, (p + 3) % NP, (s * 5 + 7) % NS);
    for (int f = 0; f < 6; f++)
      for (int s = 0; s < NS; s++) begin
        run_slot(f, s);
        if (f == 2 && s == 10) begin
          // R4: mid-frame rewrite, effective from frame 3
          for (int k = 0; k < NS; k++) set_map(0, k, 1'b1, 4, 2);   // R5 broadcast
          for (int k = 0; k < NS; k++) set_map(1, k, 1'b1, 1, k);   // R7 self map
          set_map(2, 3, 1'b0, 0, 0);                                 // R2 switched off
        end
      end
    repeat (30) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R6: missing output pulses actual %0d pending, expected 0", q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule